// File: doc/BRIEF.md
# Transmit Clock Activity Monitor

This block watches a transmit clock that arrives from the system side and judges its activity against a free-running local reference clock. The watched clock is brought into the reference domain through a synchronizer. Each change of level that the synchronizer sees restarts a timeout counter. If the counter reaches a window of `WINDOW_PS` picoseconds without a change, an alarm goes up. While the alarm is up, the transmit data word headed for the line driver is forced to all zeros.

The alarm drops by itself as soon as changes are seen again. A sticky status bit keeps a record that an alarm happened until it is cleared. A mode input picks which clock is watched: the serial bit clock, or the byte-rate parallel clock. Monitoring runs only while the enable bit is set and remote loopback is inactive. Whenever monitoring is off, the alarm is held low and data passes through untouched.

Top module: `txclk_watch`

## Requirements
- R1: After a synchronous reset, `alarm_o` and `alarm_sticky_o` are 0 and `tx_data_o` equals `tx_data_i`.
- R2: With `par_mode_i` = 1 the monitor watches `par_clk_i` and ignores `ser_clk_i`. With `par_mode_i` = 0 it watches `ser_clk_i` and ignores `par_clk_i`.
- R3: While monitoring is active, `alarm_o` rises once LIMIT consecutive reference cycles pass without a detected change of the watched clock. LIMIT is `WINDOW_PS`/`REF_PERIOD_PS` rounded up, which is 25 by default. A level change sampled at reference edge k counts as detected at edge k+2.
- R4: `tx_data_o` is all zeros while `alarm_o` is 1, and equals `tx_data_i` while `alarm_o` is 0.
- R5: The alarm clears with no outside action once the watched clock toggles again. It falls at the reference edge at which the change is detected.
- R6: `alarm_sticky_o` is set by the alarm and stays set after the alarm clears. A one-cycle `stat_clr_i` pulse clears it, unless the alarm is active in that cycle, in which case setting wins.
- R7: With `mon_en_i` = 0, `alarm_o` stays 0 and data passes, even when the watched clock is stopped. The timeout restarts from zero when monitoring is enabled again.
- R8: With `rem_loop_i` = 1, monitoring is off whatever the value of `mon_en_i`. The alarm falls combinationally in the same cycle that loopback is applied.
- R9: A watched clock whose level holds for exactly LIMIT reference cycles between changes never raises the alarm. One that holds for LIMIT+1 cycles does raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running local reference clock |
| ref_rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial transmit clock, watched in serial mode |
| par_clk_i | input | 1 | Byte-rate parallel transmit clock, watched in parallel mode |
| par_mode_i | input | 1 | 1 = watch parallel clock, 0 = watch serial clock |
| mon_en_i | input | 1 | Monitoring enable control bit |
| rem_loop_i | input | 1 | Remote loopback active; forces monitoring off |
| stat_clr_i | input | 1 | Clears the sticky alarm status |
| tx_data_i | input | DATA_W | Transmit data from the system side |
| tx_data_o | output | DATA_W | Transmit data to the line, squelched during alarm |
| alarm_o | output | 1 | Live clock-loss alarm |
| alarm_sticky_o | output | 1 | Sticky record of a clock-loss alarm |

## Verification
The watched clock is run in several patterns: fast toggling, a sudden stop, a restart, and a slow toggle that holds for exactly LIMIT and then LIMIT+1 cycles. Together these separate a correct timeout from one that is off by one in either direction. Each pattern is applied once to the serial source and once to the parallel source. Stopping the clock that is not selected tells whether the mode input really steers the watch. The stopped-clock pattern is repeated with the enable bit cleared and with loopback set, to show that each one on its own keeps the alarm low. A sticky clear issued after the alarm has ended shows that the status bit holds and then releases.

// File: rtl/txw_pkg.sv
package txw_pkg;

    typedef enum logic {
        SRC_SERIAL   = 1'b0,
        SRC_PARALLEL = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic active;
        logic seen_edge;
    } mon_ctl_t;

    function automatic int unsigned timeout_cycles(input int unsigned ref_ps,
                                                   input int unsigned win_ps);
        return (win_ps + ref_ps - 1) / ref_ps;
    endfunction

endpackage

// File: rtl/txw_src_sel.sv
module txw_src_sel
    import txw_pkg::*;
(
    input  clk_src_e src_i,
    input  logic     ser_clk_i,
    input  logic     par_clk_i,
    output logic     watched_o
);

    always_comb begin
        case (src_i)
            SRC_PARALLEL: watched_o = par_clk_i;
            default:      watched_o = ser_clk_i;
        endcase
    end

endmodule

// File: rtl/txw_edge_sync.sv
module txw_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], din};
        end
    end

    assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/txw_timeout.sv
module txw_timeout
    import txw_pkg::*;
#(
    parameter int unsigned LIMIT = 25,
    parameter int unsigned CNT_W = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  mon_ctl_t ctl_i,
    output logic     alarm_o
);

    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst || !ctl_i.active) begin
            idle_q <= '0;
        end else if (ctl_i.seen_edge) begin
            idle_q <= '0;
        end else if (idle_q != LIM_V) begin
            idle_q <= idle_q + CNT_W'(1);
        end
    end

    assign alarm_o = ctl_i.active && (idle_q == LIM_V);

    assert_idle_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        idle_q <= LIM_V);

    assert_alarm_after_window_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(alarm_o) && $past(ctl_i.active)) |-> ($past(idle_q) == LIM_V - CNT_W'(1)));

    assert_edge_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.active && ctl_i.seen_edge) |=> !alarm_o);

    assert_off_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.active |=> (idle_q == '0));

endmodule

// File: rtl/txw_gate.sv
module txw_gate #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sticky_o
);

    logic sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
        end else begin
            sticky_q <= alarm_i | (sticky_q & ~clr_i);
        end
    end

    assign sticky_o = sticky_q;
    assign data_o   = alarm_i ? '0 : data_i;

endmodule

// File: rtl/txclk_watch.sv
module txclk_watch
    import txw_pkg::*;
#(
    parameter int unsigned REF_PERIOD_PS = 8000,
    parameter int unsigned WINDOW_PS     = 200000,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              ref_clk,
    input  logic              ref_rst,
    input  logic              ser_clk_i,
    input  logic              par_clk_i,
    input  logic              par_mode_i,
    input  logic              mon_en_i,
    input  logic              rem_loop_i,
    input  logic              stat_clr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              alarm_o,
    output logic              alarm_sticky_o
);

    localparam int unsigned LIMIT = timeout_cycles(REF_PERIOD_PS, WINDOW_PS);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic     watched;
    logic     edge_seen;
    logic     alarm;
    mon_ctl_t ctl;

    txw_src_sel u_src (
        .src_i     (clk_src_e'(par_mode_i)),
        .ser_clk_i (ser_clk_i),
        .par_clk_i (par_clk_i),
        .watched_o (watched)
    );

    txw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (ref_clk),
        .rst    (ref_rst),
        .din    (watched),
        .edge_o (edge_seen)
    );

    always_comb begin
        ctl.active    = mon_en_i & ~rem_loop_i;
        ctl.seen_edge = edge_seen;
    end

    txw_timeout #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_tmo (
        .clk     (ref_clk),
        .rst     (ref_rst),
        .ctl_i   (ctl),
        .alarm_o (alarm)
    );

    txw_gate #(.DATA_W(DATA_W)) u_gate (
        .clk      (ref_clk),
        .rst      (ref_rst),
        .alarm_i  (alarm),
        .clr_i    (stat_clr_i),
        .data_i   (tx_data_i),
        .data_o   (tx_data_o),
        .sticky_o (alarm_sticky_o)
    );

    assign alarm_o = alarm;

    assert_squelch_R4: assert property (@(posedge ref_clk) disable iff (ref_rst)
        alarm_o |-> (tx_data_o == '0));

    assert_pass_R4: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !alarm_o |-> (tx_data_o == tx_data_i));

    assert_sticky_set_R6: assert property (@(posedge ref_clk) disable iff (ref_rst)
        alarm_o |=> alarm_sticky_o);

    assert_loop_override_R8: assert property (@(posedge ref_clk) disable iff (ref_rst)
        rem_loop_i |-> !alarm_o);

endmodule

// File: tb/test_txclk_watch.sv
module test_txclk_watch;

    localparam int LIMIT = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       par_clk = 1'b0;
    logic       par_mode = 1'b0;
    logic       mon_en = 1'b1;
    logic       rem_loop = 1'b0;
    logic       stat_clr = 1'b0;
    logic [7:0] din = 8'h5a;
    logic [7:0] dout;
    logic       alarm;
    logic       sticky;

    int checks = 0;
    int errors = 0;
    int ser_half = 0;
    int par_half = 0;
    int ser_cnt = 0;
    int par_cnt = 0;
    bit done = 0;
    bit alarm_seen = 0;

    // behavioural reference state
    logic hist[$];
    int   idle_m = 0;
    logic sticky_m = 1'b0;

    always #4 clk = ~clk;

    txclk_watch i_txclk_watch (
        .ref_clk        (clk),
        .ref_rst        (rst),
        .ser_clk_i      (ser_clk),
        .par_clk_i      (par_clk),
        .par_mode_i     (par_mode),
        .mon_en_i       (mon_en),
        .rem_loop_i     (rem_loop),
        .stat_clr_i     (stat_clr),
        .tx_data_i      (din),
        .tx_data_o      (dout),
        .alarm_o        (alarm),
        .alarm_sticky_o (sticky)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // stimulus clocks and data change on the falling reference edge
    always @(negedge clk) begin
        din = din + 8'h3b;
        if (ser_half != 0) begin
            ser_cnt++;
            if (ser_cnt >= ser_half) begin
                ser_clk = ~ser_clk;
                ser_cnt = 0;
            end
        end
        if (par_half != 0) begin
            par_cnt++;
            if (par_cnt >= par_half) begin
                par_clk = ~par_clk;
                par_cnt = 0;
            end
        end
    end

    // reference model
    always @(posedge clk) begin
        logic sel;
        logic act;
        logic det;
        sel = par_mode ? par_clk : ser_clk;
        act = mon_en && !rem_loop;
        if (rst) begin
            hist = '{1'b0, 1'b0, 1'b0};
            idle_m = 0;
            sticky_m = 1'b0;
        end else begin
            det = (hist[1] != hist[2]);
            sticky_m = (act && idle_m == LIMIT) || (sticky_m && !stat_clr);
            if (!act || det) idle_m = 0;
            else if (idle_m < LIMIT) idle_m++;
            hist.push_front(sel);
            void'(hist.pop_back());
        end
    end

    // cycle-by-cycle comparison
    always @(posedge clk) begin
        logic exp_alarm;
        #1;
        if (!rst) begin
            exp_alarm = mon_en && !rem_loop && idle_m == LIMIT;
            if (alarm) alarm_seen = 1;
            check("R3 alarm vs model", {7'd0, alarm}, {7'd0, exp_alarm});
            check("R4 data gate vs model", dout, exp_alarm ? 8'h00 : din);
            check("R6 sticky vs model", {7'd0, sticky}, {7'd0, sticky_m});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        @(negedge clk);
        ser_half = 2;
        cyc(4);
        @(negedge clk) rst = 1'b0;
        cyc(1);
        check("R1 alarm after reset", {7'd0, alarm}, 8'd0);
        check("R1 sticky after reset", {7'd0, sticky}, 8'd0);
        check("R1 data after reset", dout, din);
        cyc(60);
        check("R3 running serial clock", {7'd0, alarm}, 8'd0);

        // stop serial clock
        @(negedge clk) ser_half = 0;
        cyc(40);
        check("R3 stopped clock alarms", {7'd0, alarm}, 8'd1);
        check("R4 data squelched", dout, 8'h00);

        // restart
        @(negedge clk) ser_half = 2;
        cyc(8);
        check("R5 alarm clears on restart", {7'd0, alarm}, 8'd0);
        check("R6 sticky holds", {7'd0, sticky}, 8'd1);
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        cyc(1);
        check("R6 sticky cleared", {7'd0, sticky}, 8'd0);

        // parallel source
        @(negedge clk) begin par_mode = 1'b1; par_half = 3; ser_half = 0; end
        cyc(60);
        check("R2 parallel watched, serial ignored", {7'd0, alarm}, 8'd0);
        @(negedge clk) begin par_half = 0; ser_half = 2; end
        cyc(40);
        check("R2 parallel stop detected", {7'd0, alarm}, 8'd1);
        @(negedge clk) par_mode = 1'b0;
        cyc(8);
        check("R2 serial watched again", {7'd0, alarm}, 8'd0);

        // enable bit off
        @(negedge clk) begin mon_en = 1'b0; ser_half = 0; end
        cyc(40);
        check("R7 disabled no alarm", {7'd0, alarm}, 8'd0);
        check("R7 disabled data passes", dout, din);
        @(negedge clk) mon_en = 1'b1;
        cyc(20);
        check("R7 timeout restarts", {7'd0, alarm}, 8'd0);
        cyc(20);
        check("R7 re-enabled alarms", {7'd0, alarm}, 8'd1);

        // loopback override
        @(negedge clk) rem_loop = 1'b1;
        #1;
        check("R8 loopback drops alarm", {7'd0, alarm}, 8'd0);
        cyc(40);
        check("R8 loopback keeps alarm low", {7'd0, alarm}, 8'd0);
        @(negedge clk) rem_loop = 1'b0;
        cyc(40);
        check("R8 loopback released alarms", {7'd0, alarm}, 8'd1);
        @(negedge clk) ser_half = 2;
        cyc(10);

        // window boundary
        @(negedge clk) ser_half = LIMIT;
        cyc(30);
        alarm_seen = 0;
        cyc(200);
        check("R9 hold of LIMIT cycles no alarm", {7'd0, alarm_seen}, 8'd0);
        @(negedge clk) ser_half = LIMIT + 1;
        cyc(30);
        alarm_seen = 0;
        cyc(200);
        check("R9 hold of LIMIT+1 cycles alarms", {7'd0, alarm_seen}, 8'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule